// File: doc/BRIEF.md
# Word Block Copy Sequencer

This block moves a run of 32-bit words from one memory region to another with no processor help. A caller presents a source pointer, a destination pointer, a word count and a direction bit, and pulses start. The block then loops. Each pass reads one word at the source pointer and writes that same word to the destination pointer. It then steps both pointers by one word, four bytes, up or down, and takes one off the count. The loop ends when the count reaches zero.

All memory traffic goes through one request/ready port that is shared by reads and writes. A request stays up, with its address, write flag and write data held still, until the memory answers with ready. Read data is taken in the cycle that ready is high. When the loop ends, the block gives a one-cycle done pulse. It keeps the final pointers and the count on its outputs until the next start, so the caller can read where the copy stopped.

Top module: `word_copy_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o and mem_req_o are low, and src_addr_o, dst_addr_o and count_o are zero.
- R2: A start_i seen while idle with a nonzero count loads the pointers, count and direction. The first memory access after that is a read at the loaded source pointer.
- R3: Each pass reads the word at the source pointer. Only after that read completes does the block issue a write of exactly that word to the destination pointer. Passes run strictly in order, so overlapping regions are copied one word at a time.
- R4: With dir_down_i = 0, each pass adds 4 to both pointers, wrapping modulo 2^ADDR_W.
- R5: With dir_down_i = 1, each pass subtracts 4 from both pointers, wrapping modulo 2^ADDR_W.
- R6: The count drops by exactly one per pass. A copy of N words makes exactly N reads and N writes, and the count ends at zero.
- R7: A start with count_i = 0 makes no memory access. done_o is high in the cycle after the start edge.
- R8: done_o is high for exactly one cycle. While it is high and afterwards, count_o is 0 and src_addr_o / dst_addr_o show the start pointers moved by 4·N. These values stay put until the next start.
- R9: start_i has no effect while busy_o is high. The running copy finishes with its original pointers, count and direction.
- R10: While mem_req_o is high and mem_ready_i is low, mem_req_o stays high and mem_addr_o, mem_we_o and mem_wdata_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Reset, active low, synchronous |
| start_i | input | 1 | Launch a copy (acted on only while idle) |
| src_addr_i | input | ADDR_W | Source byte pointer at launch |
| dst_addr_i | input | ADDR_W | Destination byte pointer at launch |
| count_i | input | CNT_W | Number of words to copy |
| dir_down_i | input | 1 | 0: pointers step up, 1: pointers step down |
| busy_o | output | 1 | A copy is in progress (including the done cycle) |
| done_o | output | 1 | One-cycle pulse at completion |
| src_addr_o | output | ADDR_W | Current / final source pointer |
| dst_addr_o | output | ADDR_W | Current / final destination pointer |
| count_o | output | CNT_W | Words remaining |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1: write, 0: read |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Memory completes the request in this cycle |
| mem_rdata_i | input | DATA_W | Read data, valid with mem_ready_i on a read |

## Verification
The copy loop is run upward and downward, with zero and several wait states, so that pointer direction and request holding are told apart from plain sequencing. A forward copy in which the destination overlaps the source one word ahead fills the region with the first word. This shows that each write waits for its own read and that passes do not run ahead. A source pointer just below the top of the address space shows that the pointers wrap. A zero count, a single word, and a start pulse sent in the middle of a copy cover the edge of termination and the rule that start is ignored while busy.

// File: rtl/copy_seq_pkg.sv
package copy_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WRITE  = 3'd2,
        ST_UPDATE = 3'd3,
        ST_DONE   = 3'd4
    } copy_state_e;

    function automatic logic state_is_busy(copy_state_e s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/copy_ptr_step.sv
module copy_ptr_step #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic              down_i,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam logic [ADDR_W-1:0] StepV = ADDR_W'(STEP);

    always_comb begin
        if (down_i) ptr_o = ptr_i - StepV;
        else        ptr_o = ptr_i + StepV;
    end
endmodule

// File: rtl/copy_mem_drv.sv
module copy_mem_drv
    import copy_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  copy_state_e       state_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [DATA_W-1:0] hold_data_i,
    output logic              req_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    always_comb begin
        req_o   = 1'b0;
        we_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        unique case (state_i)
            ST_READ: begin
                req_o  = 1'b1;
                addr_o = src_i;
            end
            ST_WRITE: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                addr_o  = dst_i;
                wdata_o = hold_data_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/word_copy_seq.sv
module word_copy_seq
    import copy_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              dir_down_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] src_addr_o,
    output logic [ADDR_W-1:0] dst_addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    localparam int WordBytes = DATA_W / 8;
    localparam int NumPtr    = 2;
    localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

    typedef struct packed {
        copy_state_e       state;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic              dir;
        logic [DATA_W-1:0] word;
    } regs_t;

    regs_t r_d, r_q;

    // Pointer steppers: index 0 = source, index 1 = destination
    logic [ADDR_W-1:0] ptr_cur [NumPtr];
    logic [ADDR_W-1:0] ptr_nxt [NumPtr];

    assign ptr_cur[0] = r_q.src;
    assign ptr_cur[1] = r_q.dst;

    for (genvar g = 0; g < NumPtr; g++) begin : g_step
        copy_ptr_step #(
            .ADDR_W(ADDR_W),
            .STEP  (WordBytes)
        ) i_step (
            .ptr_i (ptr_cur[g]),
            .down_i(r_q.dir),
            .ptr_o (ptr_nxt[g])
        );
    end

    copy_mem_drv #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_mem_drv (
        .state_i    (r_q.state),
        .src_i      (r_q.src),
        .dst_i      (r_q.dst),
        .hold_data_i(r_q.word),
        .req_o      (mem_req_o),
        .we_o       (mem_we_o),
        .addr_o     (mem_addr_o),
        .wdata_o    (mem_wdata_o)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.src = src_addr_i;
                    r_d.dst = dst_addr_i;
                    r_d.cnt = count_i;
                    r_d.dir = dir_down_i;
                    r_d.state = (count_i == '0) ? ST_DONE : ST_READ;
                end
            end
            ST_READ: begin
                if (mem_ready_i) begin
                    r_d.word  = mem_rdata_i;
                    r_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ready_i) r_d.state = ST_UPDATE;
            end
            ST_UPDATE: begin
                r_d.src   = ptr_nxt[0];
                r_d.dst   = ptr_nxt[1];
                r_d.cnt   = r_q.cnt - CntOne;
                r_d.state = (r_q.cnt == CntOne) ? ST_DONE : ST_READ;
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign busy_o     = state_is_busy(r_q.state);
    assign done_o     = (r_q.state == ST_DONE);
    assign src_addr_o = r_q.src;
    assign dst_addr_o = r_q.dst;
    assign count_o    = r_q.cnt;

endmodule

// File: rtl/word_copy_seq_chk.sv
module word_copy_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [CNT_W-1:0]  count_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] src_addr_o,
    input logic [CNT_W-1:0]  count_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_ready_i,
    input logic [DATA_W-1:0] mem_rdata_i,
    input logic              dir_q
);
    localparam logic [ADDR_W-1:0] StepV = ADDR_W'(DATA_W / 8);

    assert_write_follows_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_we_o && mem_ready_i) |=> (mem_req_o && mem_we_o));

    assert_write_data_matches_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_we_o && mem_ready_i) |=> (mem_wdata_o == $past(mem_rdata_i)));

    assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && (src_addr_o != $past(src_addr_o)))
        |-> (src_addr_o == (dir_q ? $past(src_addr_o) - StepV : $past(src_addr_o) + StepV)));

    assert_count_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && (count_o != $past(count_o)))
        |-> (count_o == $past(count_o) - CNT_W'(1)));

    assert_zero_count_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && (count_i == '0)) |=> (done_o && !mem_req_o));

    assert_idle_no_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !mem_req_o);

    assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_count_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (count_o == '0));

    assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                         && $stable(mem_we_o) && $stable(mem_wdata_o)));

endmodule

bind word_copy_seq word_copy_seq_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .count_i    (count_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .src_addr_o (src_addr_o),
    .count_o    (count_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i),
    .mem_rdata_i(mem_rdata_i),
    .dir_q      (r_q.dir)
);

// File: tb/test_word_copy_seq.sv
module test_word_copy_seq;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_i = '0;
    logic [AW-1:0] dst_i = '0;
    logic [CW-1:0] cnt_i = '0;
    logic          down_i = 1'b0;
    logic          busy, done;
    logic [AW-1:0] src_o, dst_o;
    logic [CW-1:0] cnt_o;
    logic          mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    always #4 clk = ~clk;  // 125 MHz

    word_copy_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_word_copy_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .src_addr_i(src_i), .dst_addr_i(dst_i), .count_i(cnt_i), .dir_down_i(down_i),
        .busy_o(busy), .done_o(done), .src_addr_o(src_o), .dst_addr_o(dst_o), .count_o(cnt_o),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
    );

    // ---------------- memory model with logging ----------------
    logic [DW-1:0] mem [64];
    logic          clr = 1'b0;
    logic [7:0]    seed = 8'd0;
    int            lat = 0;
    int            wcnt, rd_cnt, wr_cnt, order_err, stab_err;
    logic [AW-1:0] first_addr, prev_addr;
    logic          last_rd, prev_wait, prev_we;

    function automatic logic [DW-1:0] pat(int i, logic [7:0] s);
        return {s, 8'(i), 8'h5A, 8'(i) ^ s};
    endfunction

    assign mem_ready = mem_req && (wcnt == lat);
    assign mem_rdata = mem[mem_addr[7:2]];

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int k = 0; k < 64; k++) mem[k] <= pat(k, seed);
            wcnt <= 0; rd_cnt <= 0; wr_cnt <= 0; order_err <= 0; stab_err <= 0;
            first_addr <= '0; last_rd <= 1'b0; prev_wait <= 1'b0;
            prev_addr <= '0; prev_we <= 1'b0;
        end else begin
            wcnt <= (mem_req && !mem_ready) ? wcnt + 1 : 0;
            if (prev_wait && (!mem_req || mem_addr != prev_addr || mem_we != prev_we))
                stab_err <= stab_err + 1;
            prev_wait <= mem_req && !mem_ready;
            prev_addr <= mem_addr;
            prev_we   <= mem_we;
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    mem[mem_addr[7:2]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                    if (!last_rd) order_err <= order_err + 1;
                    last_rd <= 1'b0;
                end else begin
                    if (rd_cnt == 0) first_addr <= mem_addr;
                    rd_cnt  <= rd_cnt + 1;
                    if (last_rd) order_err <= order_err + 1;
                    last_rd <= 1'b1;
                end
            end
        end
    end

    // ---------------- checking ----------------
    int vectors = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog: actual no finish expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    logic [DW-1:0] refm [64];

    // Runs one copy; req names the requirement the scenario targets
    task automatic run_copy(input logic [AW-1:0] s, input logic [AW-1:0] d, input int n,
                            input logic dn, input int l, input bit poke, input string req);
        logic [AW-1:0] a, b, es, ed;
        int mism, cyc;
        @(negedge clk);
        seed = seed + 8'd1; lat = l; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        for (int k = 0; k < 64; k++) refm[k] = pat(k, seed);
        a = s; b = d;
        for (int it = 0; it < n; it++) begin
            refm[b[7:2]] = refm[a[7:2]];
            a = dn ? a - 4 : a + 4;
            b = dn ? b - 4 : b + 4;
        end
        es = a; ed = b;
        src_i = s; dst_i = d; cnt_i = CW'(n); down_i = dn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            if (poke && cyc == 2) begin
                start = 1'b1; src_i = 32'h20; dst_i = 32'h24; cnt_i = 16'd9; down_i = ~dn;
            end
            if (poke && cyc == 3) start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, req, "done reached", {63'd0, done}, 64'd1);
        if (n == 0) chk(cyc == 0, "R7", "done one cycle after start", cyc, 0);
        chk(cnt_o == '0, "R6", "final count", cnt_o, 0);
        chk(src_o == es, dn ? "R5" : "R4", "final src", src_o, es);
        chk(dst_o == ed, dn ? "R5" : "R4", "final dst", dst_o, ed);
        chk(rd_cnt == n && wr_cnt == n, "R6", "reads/writes", {rd_cnt[31:0], wr_cnt[31:0]},
            {n[31:0], n[31:0]});
        chk(order_err == 0, "R3", "read-before-write order errors", order_err, 0);
        chk(stab_err == 0, "R10", "request hold errors", stab_err, 0);
        if (n > 0) chk(first_addr == s, "R2", "first read address", first_addr, s);
        mism = 0;
        for (int k = 0; k < 64; k++) if (mem[k] !== refm[k]) mism++;
        chk(mism == 0, "R3", "memory words differing", mism, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done pulse width", {63'd0, done}, 64'd0);
        repeat (2) @(negedge clk);
        chk(src_o == es && dst_o == ed && cnt_o == '0, "R8", "final values held",
            {src_o, dst_o}, {es, ed});
        chk(!busy && !mem_req, "R8", "idle after done", {62'd0, busy, mem_req}, 64'd0);
    endtask

    initial begin
        clr = 1'b1;
        repeat (3) @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !mem_req, "R1", "idle flags", {61'd0, busy, done, mem_req}, 0);
        chk(src_o == '0 && dst_o == '0 && cnt_o == '0, "R1", "pointers/count",
            {src_o, dst_o}, 64'd0);
        rst_n = 1'b1;
        run_copy(32'h0000_0000, 32'h0000_0080, 5, 1'b0, 0, 1'b0, "R4");
        run_copy(32'h0000_003C, 32'h0000_00C0, 4, 1'b1, 2, 1'b0, "R5");
        run_copy(32'h0000_0010, 32'h0000_0050, 0, 1'b0, 1, 1'b0, "R7");
        run_copy(32'h0000_0040, 32'h0000_0000, 4, 1'b0, 1, 1'b1, "R9");
        run_copy(32'hFFFF_FFF8, 32'h0000_0040, 4, 1'b0, 0, 1'b0, "R4");
        run_copy(32'h0000_0010, 32'h0000_0014, 3, 1'b0, 1, 1'b0, "R3");
        run_copy(32'h0000_0004, 32'h0000_00F0, 1, 1'b1, 3, 1'b0, "R10");
        run_copy(32'h0000_0004, 32'h0000_0000, 3, 1'b1, 0, 1'b0, "R5");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule